// File: doc/BRIEF.md
# Significand Product Normaliser

This combinational block takes the 48-bit raw product of two 24-bit significands and left-aligns it. The leading one becomes the hidden bit and is shifted out of the top, so the 48-bit result starts with the first fraction bit. A downstream rounding stage uses this vector, and the exponent path uses the carry bit and the shift count.

The two most significant product bits select one of four cases. The states are:

- NORM_CARRY: bit 47 is set. The product is shifted one place and the carry is reported.
- NORM_PLAIN: the top bits are 01. The product is shifted two places and there is no carry.
- NORM_SEARCH: the top bits are 00 and the product is non-zero, as happens when two denormals are multiplied. A priority encoder finds the leading one at or below bit 45. A barrel shifter then moves the bits beneath it to the top and reports how far past the plain case the value travelled.
- NORM_ZERO: the product is all zero. The block outputs zeros and flags the zero product.

The decode has no transitions: the case is re-selected from the current input whenever it changes.

Top module: `prod_norm`

## Requirements
- R1: When product bit 47 is 1, the output is product bits 46:0 followed by a single 0, the carry is 1 and the shift count is 0.
- R2: When product bits 47:46 are 01, the output is product bits 45:0 followed by two 0 bits, the carry is 0 and the shift count is 0.
- R3: When bits 47:46 are 00 and the leading one sits at position p (0 ≤ p ≤ 45), the output is product bits p-1:0 placed at the top, with zeros filling the low 48-p bits, and the carry is 0.
- R4: In the case of R3, the shift count equals 46 minus p, so it lies from 1 (p = 45) to 46 (p = 0).
- R5: An all-zero product gives an all-zero output, carry 0, shift count 0 and zero flag 1.
- R6: The zero flag is 0 for every non-zero product.
- R7: A product whose only set bit is bit 0 gives an all-zero output, shift count 46, carry 0 and zero flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prod_i | input | 48 | Raw significand product |
| norm_o | output | 48 | Normalised vector with the hidden bit removed |
| carry_o | output | 1 | Set when the product occupied bit 47 |
| shift_o | output | 6 | Extra left shift beyond the plain case, for exponent correction |
| zero_o | output | 1 | Set when the product is all zero |

## Verification
The hardest situations to reach are the deep search shifts, where the leading one lies near bit 0 and only a few low bits survive. Random products almost never land there. The stimulus therefore places the leading one at every position from 47 down to 0. Below that one it fills pseudo-random bits, so every shifter stage and every encoder output is exercised. The single-bit-at-0 product, which shifts everything out, and the all-zero product are also driven.

// File: rtl/prod_norm_pkg.sv
package prod_norm_pkg;

    typedef enum logic [1:0] {
        NORM_CARRY  = 2'd0,
        NORM_PLAIN  = 2'd1,
        NORM_SEARCH = 2'd2,
        NORM_ZERO   = 2'd3
    } norm_case_e;

endpackage

// File: rtl/prod_norm_lead.sv
// Priority encoder: index of the highest set bit of the search window.
module prod_norm_lead #(
    parameter int SRCH_W = 46,
    parameter int IDX_W  = 6
) (
    input  logic [SRCH_W-1:0] vec_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              found_o
);

    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        // Constant bounds; the highest set bit is the last one to write.
        for (int b = 0; b < SRCH_W; b++) begin
            if (vec_i[b]) begin
                idx_o   = IDX_W'(b);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prod_norm_shift.sv
// Logarithmic left barrel shifter with zero fill.
module prod_norm_shift #(
    parameter int DATA_W = 48,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        if (STEP >= DATA_W) begin : g_full
            assign stage[s+1] = amt_i[s] ? '0 : stage[s];
        end else begin : g_part
            assign stage[s+1] = amt_i[s] ?
                {stage[s][DATA_W-1-STEP:0], {STEP{1'b0}}} : stage[s];
        end
    end

    assign data_o = stage[AMT_W];

endmodule

// File: rtl/prod_norm_decode.sv
// Case selection from the two top product bits.
module prod_norm_decode
    import prod_norm_pkg::*;
(
    input  logic [1:0]  top_i,
    input  logic        found_i,
    output norm_case_e  case_o
);

    always_comb begin
        unique casez (top_i)
            2'b1?:   case_o = NORM_CARRY;
            2'b01:   case_o = NORM_PLAIN;
            default: case_o = found_i ? NORM_SEARCH : NORM_ZERO;
        endcase
    end

endmodule

// File: rtl/prod_norm.sv
module prod_norm
    import prod_norm_pkg::*;
#(
    parameter int PROD_W = 48
) (
    input  logic [PROD_W-1:0]         prod_i,
    output logic [PROD_W-1:0]         norm_o,
    output logic                      carry_o,
    output logic [$clog2(PROD_W)-1:0] shift_o,
    output logic                      zero_o
);

    localparam int CNT_W  = $clog2(PROD_W);
    localparam int SRCH_W = PROD_W - 2;
    localparam logic [CNT_W-1:0] SRCH_TOP = CNT_W'(SRCH_W);

    logic [CNT_W-1:0]  lead_idx;
    logic              lead_found;
    logic [CNT_W-1:0]  search_cnt;
    logic [CNT_W-1:0]  amt;
    logic [PROD_W-1:0] shifted;
    norm_case_e        sel;

    prod_norm_lead #(.SRCH_W(SRCH_W), .IDX_W(CNT_W)) u_lead (
        .vec_i   (prod_i[SRCH_W-1:0]),
        .idx_o   (lead_idx),
        .found_o (lead_found)
    );

    prod_norm_decode u_dec (
        .top_i   (prod_i[PROD_W-1:PROD_W-2]),
        .found_i (lead_found),
        .case_o  (sel)
    );

    assign search_cnt = SRCH_TOP - lead_idx;

    always_comb begin
        unique case (sel)
            NORM_CARRY:  amt = CNT_W'(1);
            NORM_PLAIN:  amt = CNT_W'(2);
            NORM_SEARCH: amt = search_cnt + CNT_W'(2);
            default:     amt = '0;
        endcase
    end

    prod_norm_shift #(.DATA_W(PROD_W), .AMT_W(CNT_W)) u_shift (
        .data_i (prod_i),
        .amt_i  (amt),
        .data_o (shifted)
    );

    always_comb begin
        norm_o  = shifted;
        carry_o = 1'b0;
        shift_o = '0;
        zero_o  = 1'b0;
        unique case (sel)
            NORM_CARRY:  carry_o = 1'b1;
            NORM_PLAIN:  ;
            NORM_SEARCH: shift_o = search_cnt;
            NORM_ZERO: begin
                norm_o = '0;
                zero_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prod_norm_chk.sv
module prod_norm_chk #(
    parameter int PROD_W = 48
) (
    input logic [PROD_W-1:0]         prod_i,
    input logic [PROD_W-1:0]         norm_o,
    input logic                      carry_o,
    input logic [$clog2(PROD_W)-1:0] shift_o,
    input logic                      zero_o
);

    localparam int SRCH_W = PROD_W - 2;

    logic [PROD_W-1:0] above;
    logic [PROD_W-1:0] moved;
    int                pos;

    always_comb begin
        pos   = SRCH_W - int'(shift_o);
        above = prod_i >> pos;
        moved = prod_i << (int'(shift_o) + 2);

        assert_carry_R1: assert (carry_o == prod_i[PROD_W-1])
            else $error("carry does not follow product top bit");

        if (prod_i[PROD_W-1:PROD_W-2] != 2'b00) begin
            assert_no_shift_R2: assert (shift_o == '0)
                else $error("shift count non-zero with top bits occupied");
        end

        if (prod_i[PROD_W-1:PROD_W-2] == 2'b00 && prod_i != '0) begin
            assert_shift_range_R4: assert (shift_o >= 1 && int'(shift_o) <= SRCH_W)
                else $error("search shift count out of range");
            assert_leading_one_R3: assert (above == PROD_W'(1))
                else $error("shift count does not point at leading one");
            assert_moved_bits_R3: assert (norm_o == moved)
                else $error("search output not aligned");
        end

        assert_zero_flag_R5: assert (zero_o == (prod_i == '0))
            else $error("zero flag wrong");

        if (zero_o) begin
            assert_zero_out_R5: assert (norm_o == '0 && shift_o == '0)
                else $error("zero product gives non-zero outputs");
        end
    end

endmodule

bind prod_norm prod_norm_chk #(.PROD_W(PROD_W)) u_chk (.*);

// File: tb/prod_norm_bench.sv
module prod_norm_bench;

    localparam int PW = 48;

    logic          clk = 1'b0;
    logic [PW-1:0] prod;
    logic [PW-1:0] norm;
    logic          carry;
    logic [5:0]    shift;
    logic          zero;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    prod_norm u_prod_norm (
        .prod_i  (prod),
        .norm_o  (norm),
        .carry_o (carry),
        .shift_o (shift),
        .zero_o  (zero)
    );

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
    endtask

    // Expected values derived from requirements; p = leading-one position or -1.
    task automatic check(input logic [PW-1:0] v, input int p, input string tag);
        logic [PW-1:0] e_norm;
        logic          e_carry;
        logic [5:0]    e_shift;
        logic          e_zero;
        logic [127:0]  wide;
        @(posedge clk);
        prod = v;
        if (p < 0) begin
            e_norm = '0; e_carry = 1'b0; e_shift = 6'd0; e_zero = 1'b1;
        end else begin
            wide    = {80'd0, v} << (PW - p);
            e_norm  = wide[PW-1:0];
            e_carry = (p == PW - 1);
            e_shift = (p < PW - 2) ? 6'(46 - p) : 6'd0;
            e_zero  = 1'b0;
        end
        @(negedge clk);
        n_chk++;
        if (norm !== e_norm || carry !== e_carry || shift !== e_shift || zero !== e_zero) begin
            n_fail++;
            $display("FAIL %s p=%0d in=%h: got norm=%h c=%b s=%0d z=%b exp norm=%h c=%b s=%0d z=%b",
                     tag, p, v, norm, carry, shift, zero, e_norm, e_carry, e_shift, e_zero);
        end
    endtask

    initial begin
        prod = '0;
        #1;
        // Reset-state / all-zero product (R5)
        check('0, -1, "R5");
        // Single bit at 0: everything shifted out (R7)
        check(48'd1, 0, "R7");
        // Lone-bit products at every position (R1 R2 R3 R4 R6)
        for (int p = 0; p < PW; p++) begin
            check(48'd1 << p, p, p == 47 ? "R1" : (p == 46 ? "R2" : "R3_R4"));
        end
        // Leading one at each position with pseudo-random lower bits
        for (int p = 0; p < PW; p++) begin
            for (int k = 0; k < 40; k++) begin
                logic [PW-1:0] mask;
                logic [PW-1:0] v;
                next_rng();
                mask = (p == 0) ? '0 : ({PW{1'b1}} >> (PW - p));
                v    = (48'd1 << p) | (rng[PW-1:0] & mask);
                check(v, p, p == 47 ? "R1_R6" : (p == 46 ? "R2_R6" : "R3_R4_R6"));
            end
        end
        // All ones below the leading one (R3 R4)
        for (int p = 1; p < PW - 2; p++) begin
            check({PW{1'b1}} >> (PW - 1 - p), p, "R3_R4");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule